// File: doc/BRIEF.md
# Four-residue to binary reverse converter

The block takes an integer given as four residues and returns its ordinary binary value. The four moduli are 2^n, 2^(2n)+1, 2^n+1 and 2^n-1. They are pairwise coprime, so the product M = 2^n·(2^(4n)-1) bounds the range that can be recovered, which is 0 to M-1 in 5n output bits. A datapath that does its arithmetic in residue form places the block at its exit, to bring results back into positional binary.

The residue modulo 2^n passes straight through as the low n bits of the result. The upper 4n bits are a weighted sum of the residues reduced modulo 2^(4n)-1. Every weight is a signed power-of-two combination. Each product is therefore a fixed rotation of a 4n-bit word, with a bitwise inversion where the weight is negative. Five such operands go through three carry-save levels with end-around carry and then one end-around-carry adder. The word size n is a parameter. An optional register, on by default, holds the result for one clock.

Top module: `rns4_to_bin`

## Requirements
- R1: While rst_n is low, bin_out reads zero. This holds with the default output register.
- R2: With the default output register, bin_out shows the value for the residues present at a rising clock edge after that edge, and holds it until the next edge.
- R3: Bits [n-1:0] of bin_out always equal res_a, the residue modulo 2^n.
- R4: For n=2, every residue tuple converts to the unique X in 0..1019 with X mod 4 = res_a, X mod 17 = res_b, X mod 5 = res_c and X mod 3 = res_d. That is 4·17·5·3 = 1020 tuples.
- R5: For n=4, random tuples taken from X in 0..1048559 convert back to that X.
- R6: Any X below 2^n yields zero in bits [5n-1:n].
- R7: Bits [5n-1:n] never read all ones. X = M-1 yields 2^(4n)-2 there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| res_a | input | n | Residue modulo 2^n |
| res_b | input | 2n+1 | Residue modulo 2^(2n)+1 |
| res_c | input | n+1 | Residue modulo 2^n+1 |
| res_d | input | n | Residue modulo 2^n-1 |
| bin_out | output | 5n | Recovered binary integer |

## Verification
The hardest case to reach from the ports is the final end-around-carry sum landing exactly on 2^(4n)-1, the second code for zero, which must be folded to zero. This happens when the weighted sum is a multiple of the modulus. Numbers below 2^n give exactly that. The stimulus sweeps them on purpose at both word sizes, together with the top value M-1 and the full tuple space at n=2. Every tuple is generated from a chosen integer, so the expected output is that integer.

// File: rtl/rns4_to_bin.sv
module rns4_to_bin #(
  parameter int N       = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   res_a,
  input  logic [2*N:0]   res_b,
  input  logic [N:0]     res_c,
  input  logic [N-1:0]   res_d,
  output logic [5*N-1:0] bin_out
);
  localparam int W = 4 * N;
  localparam logic [W-1:0] ONES = '1;
  localparam logic [W+2:0] PMOD = {3'b000, ONES};

  function automatic logic [W-1:0] rotl(input logic [W-1:0] v, input int s);
    rotl = (v << s) | (v >> (W - s));
  endfunction

  function automatic logic [W-1:0] csa_sum(input logic [W-1:0] a, b, c);
    csa_sum = a ^ b ^ c;
  endfunction

  function automatic logic [W-1:0] csa_cry(input logic [W-1:0] a, b, c);
    csa_cry = rotl((a & b) | (a & c) | (b & c), 1);
  endfunction

  logic [W-1:0] c_img, op_b_hi, op_ab, op_c_pos, op_c_neg, op_d;
  logic [W-1:0] s1, k1, s2, k2, s3, k3;
  logic [W:0]   wide;
  logic [W-1:0] fold, y;
  logic [5*N-1:0] conv;

  assign c_img    = {{(N-1){1'b0}}, res_c, {(N-1){1'b0}}, res_c};
  assign op_b_hi  = {res_b[N:0], {(2*N-1){1'b0}}, res_b[2*N:N+1]};
  assign op_ab    = {~res_a, ~res_b, {(N-1){1'b1}}};
  assign op_c_pos = rotl(c_img, N - 2);
  assign op_c_neg = ~rotl(c_img, 2 * N - 2);
  assign op_d     = rotl({4{res_d}}, N - 2);

  assign s1 = csa_sum(op_b_hi, op_ab, op_c_pos);
  assign k1 = csa_cry(op_b_hi, op_ab, op_c_pos);
  assign s2 = csa_sum(s1, k1, op_c_neg);
  assign k2 = csa_cry(s1, k1, op_c_neg);
  assign s3 = csa_sum(s2, k2, op_d);
  assign k3 = csa_cry(s2, k2, op_d);

  assign wide = {1'b0, s3} + {1'b0, k3};
  assign fold = wide[W-1:0] + {{(W-1){1'b0}}, wide[W]};
  assign y    = (fold == ONES) ? '0 : fold;
  assign conv = {y, res_a};

  logic [W+2:0] tot5, tot2;
  assign tot5 = {3'b000, op_b_hi} + {3'b000, op_ab} + {3'b000, op_c_pos}
              + {3'b000, op_c_neg} + {3'b000, op_d};
  assign tot2 = {3'b000, s3} + {3'b000, k3};

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bin_out <= '0;
        else        bin_out <= conv;
      end

      AST_CSA_KEEPS_RESIDUE: assert property (@(posedge clk) disable iff (!rst_n)
        (tot5 % PMOD) == (tot2 % PMOD)); // R4
      AST_FINAL_ADD: assert property (@(posedge clk) disable iff (!rst_n)
        (tot2 % PMOD) == {3'b000, y}); // R4
      AST_LOW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> bin_out[N-1:0] == $past(res_a)); // R3
      AST_NOT_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        bin_out[5*N-1:N] != ONES); // R7
    end else begin : g_comb
      assign bin_out = conv;
    end
  endgenerate
endmodule

// File: tb/rns4_to_bin_tb.sv
module rns4_to_bin_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0] a2; logic [4:0] b2; logic [2:0] c2; logic [1:0] d2; logic [9:0]  o2;
  logic [3:0] a4; logic [8:0] b4; logic [4:0] c4; logic [3:0] d4; logic [19:0] o4;

  rns4_to_bin #(.N(2)) u_dut (.clk(clk), .rst_n(rst_n), .res_a(a2), .res_b(b2),
                              .res_c(c2), .res_d(d2), .bin_out(o2));
  rns4_to_bin #(.N(4)) u_dut4 (.clk(clk), .rst_n(rst_n), .res_a(a4), .res_b(b4),
                               .res_c(c4), .res_d(d4), .bin_out(o4));

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input string tag, input longint got, input longint exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic drive2(input longint x);
    a2 = 2'(x % 4); b2 = 5'(x % 17); c2 = 3'(x % 5); d2 = 2'(x % 3);
  endtask

  task automatic drive4(input longint x);
    a4 = 4'(x % 16); b4 = 9'(x % 257); c4 = 5'(x % 17); d4 = 4'(x % 15);
  endtask

  task automatic run2(input longint x, input string tag);
    @(negedge clk); drive2(x);
    @(posedge clk); #1;
    chk(tag, longint'(o2), x);
  endtask

  task automatic run4(input longint x, input string tag);
    @(negedge clk); drive4(x);
    @(posedge clk); #1;
    chk(tag, longint'(o4), x);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #500000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    longint m4;
    m4 = 64'd1048560;
    drive2(longint'(1019)); drive4(longint'(777));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset n=2", longint'(o2), 0);
    chk("R1 reset n=4", longint'(o4), 0);
    @(negedge clk); rst_n = 1'b1;

    run2(longint'(300), "R2 setup");
    @(negedge clk); drive2(longint'(7)); #1;
    chk("R2 holds before edge", longint'(o2), 300);
    @(posedge clk); #1;
    chk("R2 updates after edge", longint'(o2), 7);

    for (int x = 0; x < 1020; x++) run2(longint'(x), "R4 sweep n=2");

    for (int x = 0; x < 4; x++) begin
      run2(longint'(x), "R6 small n=2");
      chk("R6 upper zero n=2", longint'(o2 >> 2), 0);
    end
    for (int x = 0; x < 16; x++) begin
      run4(longint'(x), "R6 small n=4");
      chk("R6 upper zero n=4", longint'(o4 >> 4), 0);
    end

    run2(longint'(1019), "R7 top n=2");
    chk("R7 upper n=2", longint'(o2 >> 2), 254);
    run4(m4 - 1, "R7 top n=4");
    chk("R7 upper n=4", longint'(o4 >> 4), 65534);

    for (int i = 0; i < 3000; i++) begin
      longint x;
      x = longint'({$urandom, $urandom}) & 64'h7fff_ffff_ffff_ffff;
      x = x % m4;
      run4(x, "R5 random n=4");
      chk("R3 low bits n=4", longint'(o4 & 20'hf), x % 16);
      if (longint'(o4 >> 4) == 65535) chk("R7 no all ones", longint'(o4 >> 4), 0);
    end

    summary();
    $finish;
  end
endmodule